// File: doc/BRIEF.md
# Masked Gouraud Span Colour Writer

This block is the colour stage of a scanline span renderer. A depth stage that runs earlier leaves one visibility bit per pixel in a small two-bit-wide buffer. This block then steps across the same span, one pixel per clock. It interpolates red, green and blue in fixed point and sends a packed pixel to the frame buffer. Each pixel carries a write enable equal to its stored visibility bit.

A span is started with a one-cycle `start` pulse. The pulse carries the first pixel, the exclusive end pixel, three start colours and three per-pixel colour steps. The colour accumulators advance on every pixel, whether or not that pixel is written, so the colour of each pixel depends only on its distance from the span start. The colour is written as computed, with no blending or texturing. A one-cycle `done` marks the cycle after the last pixel.

Top module: `span_shade_writer`

## Requirements
- R1: After a `start` pulse seen in idle at clock edge k, the pixel at offset j (x = x_begin + j, for x_begin <= x < x_end) is presented on `wr_addr` in the cycle after edge k+1+j. There is one pixel per clock, in ascending order, with no gaps.
- R2: Red and green are 24-bit accumulators in 16.8 fixed point. Pixel j uses init + j*step modulo 2^24. Its 8-bit channel value is accumulator bits [23:16].
- R3: Blue is a 16-bit accumulator in 8.8 fixed point. Pixel j uses init + j*step modulo 2^16. Its 8-bit channel value is accumulator bits [15:8].
- R4: `wr_en` for a pixel equals that pixel's visibility bit. Colour for later pixels advances whether or not earlier pixels were written.
- R5: The visibility bit for pixel x is read at `vis_addr` = x/2. Bit 0 of the returned entry serves even x and bit 1 serves odd x.
- R6: `wr_data` is {8'h00, red[7:0], green[7:0], blue[7:0]}, with red in bits [23:16] and blue in bits [7:0].
- R7: `done` is high for exactly one cycle, in the cycle after edge k+n+1 for a span of n pixels. With x_begin >= x_end, n is 0, no pixel is written, and `done` follows one cycle after the start edge.
- R8: `busy` is high from the start edge until the `done` edge. A `start` seen while busy has no effect on the running span and launches no second span.
- R9: During reset, `wr_en`, `done` and `busy` are low.
- R10: The accumulators wrap modulo their width. No saturation is applied, and negative steps are given in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a span (honoured only when idle) |
| x_begin | input | 8 | First pixel of the span |
| x_end | input | 8 | Exclusive end pixel of the span |
| red_init | input | 24 | Red start, 16.8 |
| red_step | input | 24 | Red per-pixel step, 16.8 |
| grn_init | input | 24 | Green start, 16.8 |
| grn_step | input | 24 | Green per-pixel step, 16.8 |
| blu_init | input | 16 | Blue start, 8.8 |
| blu_step | input | 16 | Blue per-pixel step, 8.8 |
| vis_addr | output | 6 | Visibility buffer read index |
| vis_data | input | 2 | Visibility entry at `vis_addr`, same cycle |
| busy | output | 1 | Span in progress |
| wr_en | output | 1 | Frame-buffer write strobe |
| wr_addr | output | 7 | Pixel address of the write |
| wr_data | output | 32 | Packed pixel |
| done | output | 1 | One-cycle end-of-span pulse |

## Verification
The bench runs spans that start and end on both even and odd pixels, one-pixel spans, an empty span, and a span covering the whole buffer. A design that swapped the lane bits, or that halved the address wrongly, would write the neighbouring pixel's visibility. Steps are chosen so that the fractional bits carry into the integer part, and negative steps force wraparound. A design that froze colour on masked pixels, took the wrong slice or saturated would show a colour drift after the first hidden pixel. The bench also pulses `start` while a span runs. A design that reloaded would jump its address or produce an extra `done`.

// File: rtl/span_shade_pkg.sv
package span_shade_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_FLUSH = 2'd2
   } span_state_t;
endpackage

// File: rtl/shade_accum.sv
module shade_accum #(
   parameter int W    = 24,
   parameter int FRAC = 8,
   parameter int CH_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            adv,
   input  logic [W-1:0]    init,
   input  logic [W-1:0]    step,
   output logic [CH_W-1:0] chan
);
   localparam int INT_W = W - FRAC;

   generate
      if (INT_W < CH_W) begin : g_bad_int
         $error("shade_accum: integer part narrower than channel");
      end
   endgenerate

   logic [W-1:0] acc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0;
      end else if (load) begin
         acc <= init;
      end else if (adv) begin
         acc <= acc + step;
      end
   end

   assign chan = acc[W-1 -: CH_W];

   // R2 / R3 / R10: modular step on every advance
   p_accum_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=> (acc == W'($past(acc) + $past(step))));
endmodule

// File: rtl/vis_lookup.sv
module vis_lookup #(
   parameter int VIS_DEPTH = 64,
   parameter int LANES     = 2
) (
   input  logic [$clog2(VIS_DEPTH*LANES)-1:0] x,
   input  logic [LANES-1:0]                   vis_data,
   output logic [$clog2(VIS_DEPTH)-1:0]       vis_addr,
   output logic                               hit
);
   localparam int XW   = $clog2(VIS_DEPTH*LANES);
   localparam int LS_W = (LANES > 1) ? $clog2(LANES) : 1;

   generate
      if ((LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("vis_lookup: LANES must be a power of two");
      end
      if (LANES == 1) begin : g_single
         assign vis_addr = x;
         assign hit      = vis_data[0];
      end else begin : g_multi
         assign vis_addr = x[XW-1:LS_W];
         assign hit      = vis_data[x[LS_W-1:0]];
      end
   endgenerate
endmodule

// File: rtl/pixel_pack.sv
module pixel_pack #(
   parameter int CH_W  = 8,
   parameter int PIX_W = 32
) (
   input  logic [CH_W-1:0]  red,
   input  logic [CH_W-1:0]  grn,
   input  logic [CH_W-1:0]  blu,
   output logic [PIX_W-1:0] pix
);
   localparam int USED = 3 * CH_W;

   generate
      if (PIX_W < USED) begin : g_bad_pix
         $error("pixel_pack: pixel narrower than three channels");
      end else if (PIX_W == USED) begin : g_exact
         assign pix = {red, grn, blu};
      end else begin : g_pad
         assign pix = {{(PIX_W-USED){1'b0}}, red, grn, blu};
      end
   endgenerate
endmodule

// File: rtl/span_shade_writer.sv
module span_shade_writer
   import span_shade_pkg::*;
#(
   parameter int VIS_DEPTH = 64,
   parameter int LANES     = 2,
   parameter int RG_W      = 24,
   parameter int RG_FRAC   = 8,
   parameter int B_W       = 16,
   parameter int B_FRAC    = 8,
   parameter int CH_W      = 8,
   parameter int PIX_W     = 32,
   localparam int XW       = $clog2(VIS_DEPTH*LANES),
   localparam int BW       = XW + 1,
   localparam int VA_W     = $clog2(VIS_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [BW-1:0]    x_begin,
   input  logic [BW-1:0]    x_end,
   input  logic [RG_W-1:0]  red_init,
   input  logic [RG_W-1:0]  red_step,
   input  logic [RG_W-1:0]  grn_init,
   input  logic [RG_W-1:0]  grn_step,
   input  logic [B_W-1:0]   blu_init,
   input  logic [B_W-1:0]   blu_step,
   output logic [VA_W-1:0]  vis_addr,
   input  logic [LANES-1:0] vis_data,
   output logic             busy,
   output logic             wr_en,
   output logic [XW-1:0]    wr_addr,
   output logic [PIX_W-1:0] wr_data,
   output logic             done
);
   span_state_t          state;
   logic [BW-1:0]        x_cur;
   logic [BW-1:0]        x_stop;
   logic [BW-1:0]        x_nxt;
   logic                 pix_valid;
   logic                 launch;
   logic                 stepping;
   logic                 hit;
   logic [CH_W-1:0]      ch_r, ch_g, ch_b;
   logic [PIX_W-1:0]     pix;

   assign launch   = (state == ST_IDLE) && start;
   assign stepping = (state == ST_RUN);
   assign busy     = (state != ST_IDLE);
   assign x_nxt    = x_cur + {{(BW-1){1'b0}}, 1'b1};

   shade_accum #(.W(RG_W), .FRAC(RG_FRAC), .CH_W(CH_W)) u_red (
      .clk(clk), .rst_n(rst_n), .load(launch), .adv(stepping),
      .init(red_init), .step(red_step), .chan(ch_r));

   shade_accum #(.W(RG_W), .FRAC(RG_FRAC), .CH_W(CH_W)) u_grn (
      .clk(clk), .rst_n(rst_n), .load(launch), .adv(stepping),
      .init(grn_init), .step(grn_step), .chan(ch_g));

   shade_accum #(.W(B_W), .FRAC(B_FRAC), .CH_W(CH_W)) u_blu (
      .clk(clk), .rst_n(rst_n), .load(launch), .adv(stepping),
      .init(blu_init), .step(blu_step), .chan(ch_b));

   vis_lookup #(.VIS_DEPTH(VIS_DEPTH), .LANES(LANES)) u_vis (
      .x(x_cur[XW-1:0]), .vis_data(vis_data),
      .vis_addr(vis_addr), .hit(hit));

   pixel_pack #(.CH_W(CH_W), .PIX_W(PIX_W)) u_pack (
      .red(ch_r), .grn(ch_g), .blu(ch_b), .pix(pix));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         x_cur     <= '0;
         x_stop    <= '0;
         pix_valid <= 1'b0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         done      <= 1'b0;
      end else begin
         done      <= 1'b0;
         wr_en     <= 1'b0;
         pix_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  x_cur  <= x_begin;
                  x_stop <= x_end;
                  state  <= (x_begin < x_end) ? ST_RUN : ST_FLUSH;
               end
            end
            ST_RUN: begin
               wr_en     <= hit;
               wr_addr   <= x_cur[XW-1:0];
               wr_data   <= pix;
               pix_valid <= 1'b1;
               x_cur     <= x_nxt;
               if (x_nxt == x_stop) state <= ST_FLUSH;
            end
            ST_FLUSH: begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R1: consecutive pixels advance by one address
   p_addr_consecutive_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && $past(pix_valid)) |-> (wr_addr == XW'($past(wr_addr) + 1'b1)));

   // R4: a write strobe only follows a stepping cycle
   p_write_from_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(state == ST_RUN));

   // R7: done is a single-cycle pulse with no write beside it
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!wr_en && !busy));

   // R8: span bounds stay fixed while a span is in flight
   p_hold_bounds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(x_stop));
endmodule

// File: tb/span_shade_writer_test.sv
module span_shade_writer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  x_begin = '0, x_end = '0;
   logic [23:0] red_init = '0, red_step = '0, grn_init = '0, grn_step = '0;
   logic [15:0] blu_init = '0, blu_step = '0;
   logic [5:0]  vis_addr;
   logic [1:0]  vis_data;
   logic        busy, wr_en, done;
   logic [6:0]  wr_addr;
   logic [31:0] wr_data;
   logic [1:0]  vis_mem [0:63];
   int          n_cmp = 0;
   int          n_bad = 0;

   always #10 clk = ~clk;

   assign vis_data = vis_mem[vis_addr];

   span_shade_writer uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .x_begin(x_begin), .x_end(x_end),
      .red_init(red_init), .red_step(red_step),
      .grn_init(grn_init), .grn_step(grn_step),
      .blu_init(blu_init), .blu_step(blu_step),
      .vis_addr(vis_addr), .vis_data(vis_data),
      .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .done(done));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic fill_vis(input int mode);
      for (int i = 0; i < 64; i++) begin
         case (mode)
            0: vis_mem[i] = 2'(i * 5 + 3);
            1: vis_mem[i] = 2'b11;
            2: vis_mem[i] = 2'b01;
            default: vis_mem[i] = 2'((i >> 1) ^ i);
         endcase
      end
   endtask

   task automatic run_span(input int xb, input int xe,
                           input logic [23:0] ri, input logic [23:0] rs,
                           input logic [23:0] gi, input logic [23:0] gs,
                           input logic [15:0] bi, input logic [15:0] bs,
                           input bit poke);
      int n;
      n = (xe > xb) ? xe - xb : 0;
      @(negedge clk);
      x_begin = 8'(xb); x_end = 8'(xe);
      red_init = ri; red_step = rs; grn_init = gi; grn_step = gs;
      blu_init = bi; blu_step = bs;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk("R8 busy after start", 32'(busy), 32'd1);
      for (int j = 0; j < n; j++) begin
         logic [23:0] er, eg;
         logic [15:0] eb;
         int          x;
         logic        ev;
         if (poke && j == 1) begin
            // R8: stray start mid-span with different bounds
            x_begin = 8'd0; x_end = 8'd1; red_init = 24'hFFFFFF; start = 1'b1;
         end
         @(negedge clk);
         if (poke && j == 1) start = 1'b0;
         x  = xb + j;
         er = ri + rs * 24'(j);
         eg = gi + gs * 24'(j);
         eb = bi + bs * 16'(j);
         ev = vis_mem[x >> 1][x & 1];
         chk("R1 wr_addr", 32'(wr_addr), 32'(x));
         chk("R4/R5 wr_en", 32'(wr_en), 32'(ev));
         if (ev) begin
            chk("R6 pad byte", 32'(wr_data[31:24]), 32'd0);
            chk("R2/R10 red", 32'(wr_data[23:16]), 32'(er[23:16]));
            chk("R2/R10 green", 32'(wr_data[15:8]), 32'(eg[23:16]));
            chk("R3/R10 blue", 32'(wr_data[7:0]), 32'(eb[15:8]));
         end
         chk("R7 no early done", 32'(done), 32'd0);
      end
      @(negedge clk);
      chk("R7 done pulse", 32'(done), 32'd1);
      chk("R7 no write with done", 32'(wr_en), 32'd0);
      @(negedge clk);
      chk("R7 done one cycle", 32'(done), 32'd0);
      chk("R8 idle after done", 32'(busy), 32'd0);
      chk("R8 no extra write", 32'(wr_en), 32'd0);
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      fill_vis(0);
      repeat (3) @(negedge clk);
      chk("R9 wr_en in reset", 32'(wr_en), 32'd0);
      chk("R9 done in reset", 32'(done), 32'd0);
      chk("R9 busy in reset", 32'(busy), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // full buffer, carries from fraction into integer
      run_span(0, 128, 24'h000080, 24'h0001C0, 24'hFF0000, 24'hFFFE40,
               16'h0040, 16'h0180, 1'b0);
      // every start offset with short spans, odd and even ends
      for (int xb = 0; xb < 8; xb++) begin
         for (int len = 0; len < 4; len++) begin
            run_span(xb, xb + len, 24'(xb * 24'h1357), 24'h012345,
                     24'h7F8000, 24'hFF8001, 16'(xb * 16'h0311), 16'hFF90, 1'b0);
         end
      end
      // empty span with begin past end
      run_span(20, 10, 24'h0, 24'h1, 24'h0, 24'h1, 16'h0, 16'h1, 1'b0);
      // all visible, stray start mid-span
      fill_vis(1);
      run_span(7, 40, 24'h10_0000, 24'h00_8000, 24'h00_0000, 24'h03_0001,
               16'hF000, 16'h0123, 1'b1);
      // only even pixels visible: colour must still advance on hidden odd pixels
      fill_vis(2);
      run_span(3, 30, 24'h000000, 24'h040000, 24'h800000, 24'hF80000,
               16'h0000, 16'h0800, 1'b0);
      fill_vis(3);
      run_span(100, 128, 24'hFFFF00, 24'h000100, 24'h123456, 24'h00ABCD,
               16'hFFFF, 16'h0001, 1'b1);
      run_span(127, 128, 24'hAB0000, 24'h0, 24'hCD0000, 24'h0, 16'hEF00, 16'h0, 1'b0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule